// File: doc/BRIEF.md
# Power and Clock Gating Controller

This block gates the clock and the local reset of a set of peripheral modules. The modules are grouped into power domains. Software programs each module through a simple register port. It writes the state the module should enter next and, if needed, asks for the module's domain to be powered up. Nothing changes at the module yet: the new values are only staged.

Software then writes a one-hot command word that names the domains to move. For each named domain the block copies the staged settings, raises that domain's busy flag for a fixed number of cycles, and then applies them all at once. At that point it updates each module's applied state, its clock-enable output and its reset output, and it powers the domain on if that was asked for. Software polls the busy flags to learn when the transition has finished.

Top module: `pcg_ctrl`

## Requirements
- R1: After reset:
  - every module control word reads 0x0000_0100 and every module status word reads 0;
  - domain status, domain control and transition status all read 0;
  - `mod_clk_en`, `mod_rst_n` and `dom_pwr_on` are all 0.
- R2: A write to module control (offset 0xA00 + 4*m) changes only that word's readback. Bits 31 (force), 8 (local reset release, active-low reset) and [5:0] (next state) are kept, and all other bits read 0. Module status and outputs do not change until a transition of the module's domain completes. A write made after a transition has started waits for the next transition.
- R3: Writing 1 to bit d of the command register (offset 0x120) starts a transition for domain d. Bit d of the transition status register (offset 0x128) then reads 1 for exactly T_CYC cycles (default 8), starting in the cycle after the write.
- R4: Module m belongs to domain m / 2, and its status is at offset 0x800 + 4*m. When a transition of that domain completes, status bits [5:0] of each of its modules equal the next state captured when the transition started. Modules of other domains are unchanged.
- R5: Module status bit 12 and `mod_clk_en[m]` are 1 exactly when the applied state is 3 (enable). The other state codes are 0 (software reset, disabled), 1 (synchronous reset) and 2 (clock off, out of reset).
- R6: Module status bit 8 and `mod_rst_n[m]` are 1 exactly when two conditions hold:
  - the applied state is 2 or 3;
  - control bit 8, as captured at the transition's start, was 1.
- R7: Bit 0 of domain control (offset 0x300 + 4*d) is a power-up request. If it is 1 when a transition starts:
  - it reads 0 from the next cycle;
  - at completion, domain status (offset 0x200 + 4*d, bits [4:0]) reads 1 and `dom_pwr_on[d]` is 1;
  - the domain then stays on.
- R8: A command for a domain that is already busy is ignored. Busy still ends at the original time, and the settings captured at the original start are the ones applied.
- R9: Several domains named in one command word run at the same time, and each completes with its own settings.
- R10: Reading the command register or any unmapped offset returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| mod_clk_en | output | 8 | Per-module clock enable |
| mod_rst_n | output | 8 | Per-module active-low reset |
| dom_pwr_on | output | 4 | Per-domain power-on |

## Verification
The assertions assume a single register master. They assume at most one write per cycle and a legal command word, meaning no bits set above the domain count. The stimulus keeps to this by issuing every access through one write task, and its random command masks use only the low four bits. Random phases always let every domain finish before the next command is issued. Commands that overlap a running transition, and control writes made while a domain is busy, appear only in directed cases.

// File: rtl/pcg_pkg.sv
// Package: shared constants and helpers for the gating controller.
// Assumes register offsets fit within a 12-bit byte address.
package pcg_pkg;
    localparam int unsigned OFF_CMD   = 32'h120;
    localparam int unsigned OFF_TSTAT = 32'h128;
    localparam int unsigned OFF_DSTAT = 32'h200;
    localparam int unsigned OFF_DCTL  = 32'h300;
    localparam int unsigned OFF_MSTAT = 32'h800;
    localparam int unsigned OFF_MCTL  = 32'hA00;

    localparam logic [5:0] ST_SWRST_OFF = 6'd0;
    localparam logic [5:0] ST_SYNC_RST  = 6'd1;
    localparam logic [5:0] ST_CLK_OFF   = 6'd2;
    localparam logic [5:0] ST_RUN       = 6'd3;

    // Readback layout of a module control word.
    function automatic logic [31:0] ctl_word(logic [5:0] st, logic lrel, logic frc);
        return {frc, 22'b0, lrel, 2'b0, st};
    endfunction

    // Readback layout of a module status word.
    function automatic logic [31:0] stat_word(logic [5:0] st, logic clk_on, logic rel);
        return {19'b0, clk_on, 3'b0, rel, 2'b0, st};
    endfunction
endpackage

// File: rtl/pcg_dom_seq.sv
// Per-domain transition sequencer. Accepts a start pulse when idle and counts
// T_CYC cycles of busy. It pulses take_o on acceptance and done_o in the
// last busy cycle. It also holds the domain power-up request and the
// power state. Assumes T_CYC >= 1.
module pcg_dom_seq #(
    parameter int unsigned T_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic req_wr_i,
    input  logic req_val_i,
    output logic busy_o,
    output logic take_o,
    output logic done_o,
    output logic req_o,
    output logic on_o
);
    localparam int unsigned CW = $clog2(T_CYC + 1);

    logic [CW-1:0] cnt_q;
    logic          req_q;
    logic          pend_q;
    logic          on_q;

    // Start is accepted only while idle; done marks the final busy cycle.
    assign take_o = start_i && (cnt_q == '0);
    assign done_o = (cnt_q == CW'(1));
    assign busy_o = (cnt_q != '0);
    assign req_o  = req_q;
    assign on_o   = on_q;

    // Busy countdown, request capture and power state update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            req_q  <= 1'b0;
            pend_q <= 1'b0;
            on_q   <= 1'b0;
        end else begin
            if (take_o) begin
                cnt_q <= CW'(T_CYC);
            end else if (cnt_q != '0) begin
                cnt_q <= cnt_q - CW'(1);
            end

            if (take_o) begin
                pend_q <= req_q;
                req_q  <= 1'b0;
            end else begin
                if (req_wr_i) begin
                    req_q <= req_val_i;
                end
                if (done_o) begin
                    pend_q <= 1'b0;
                    if (pend_q) begin
                        on_q <= 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/pcg_mod_slot.sv
// Per-module slot. Holds the staged control fields, snapshots them when its
// domain accepts a transition, and applies the snapshot when the transition
// is done. It drives the module's clock enable and reset from the applied
// values. Assumes take_i and done_i never fire in the same cycle.
module pcg_mod_slot
    import pcg_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_i,
    input  logic [5:0]  w_state_i,
    input  logic        w_lrel_i,
    input  logic        w_force_i,
    input  logic        take_i,
    input  logic        done_i,
    output logic [31:0] ctl_o,
    output logic [31:0] stat_o,
    output logic        clk_en_o,
    output logic        rst_n_o
);
    logic [5:0] nxt_q;
    logic       lrel_q;
    logic       frc_q;
    logic [5:0] snap_st_q;
    logic       snap_lrel_q;
    logic [5:0] cur_st_q;
    logic       cur_lrel_q;

    // Staged control fields written by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nxt_q  <= ST_SWRST_OFF;
            lrel_q <= 1'b1;
            frc_q  <= 1'b0;
        end else if (wr_i) begin
            nxt_q  <= w_state_i;
            lrel_q <= w_lrel_i;
            frc_q  <= w_force_i;
        end
    end

    // Snapshot at transition start, apply at transition end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_st_q   <= ST_SWRST_OFF;
            snap_lrel_q <= 1'b1;
            cur_st_q    <= ST_SWRST_OFF;
            cur_lrel_q  <= 1'b1;
        end else begin
            if (take_i) begin
                snap_st_q   <= nxt_q;
                snap_lrel_q <= lrel_q;
            end
            if (done_i) begin
                cur_st_q   <= snap_st_q;
                cur_lrel_q <= snap_lrel_q;
            end
        end
    end

    // Output decode from the applied state.
    always_comb begin
        clk_en_o = (cur_st_q == ST_RUN);
        rst_n_o  = cur_lrel_q && ((cur_st_q == ST_RUN) || (cur_st_q == ST_CLK_OFF));
        ctl_o    = ctl_word(nxt_q, lrel_q, frc_q);
        stat_o   = stat_word(cur_st_q, clk_en_o, rst_n_o);
    end
endmodule

// File: rtl/pcg_rd_mux.sv
// Register read multiplexer. Purely combinational, and returns 0 for
// unmapped offsets. Assumes N_DOM <= 32.
module pcg_rd_mux
    import pcg_pkg::*;
#(
    parameter int unsigned N_DOM  = 4,
    parameter int unsigned N_MOD  = 8,
    parameter int unsigned ADDR_W = 12
) (
    input  logic [ADDR_W-1:0]          addr_i,
    input  logic [N_DOM-1:0]           busy_i,
    input  logic [N_DOM-1:0]           on_i,
    input  logic [N_DOM-1:0]           req_i,
    input  logic [N_MOD-1:0][31:0]     ctl_i,
    input  logic [N_MOD-1:0][31:0]     stat_i,
    output logic [31:0]                rdata_o
);
    // Address decode and selection of the read word.
    always_comb begin
        rdata_o = '0;
        if (addr_i == ADDR_W'(OFF_TSTAT)) begin
            rdata_o = 32'(busy_i);
        end
        for (int d = 0; d < int'(N_DOM); d++) begin
            if (addr_i == ADDR_W'(OFF_DSTAT + 4 * d)) begin
                rdata_o = {31'b0, on_i[d]};
            end
            if (addr_i == ADDR_W'(OFF_DCTL + 4 * d)) begin
                rdata_o = {31'b0, req_i[d]};
            end
        end
        for (int m = 0; m < int'(N_MOD); m++) begin
            if (addr_i == ADDR_W'(OFF_MSTAT + 4 * m)) begin
                rdata_o = stat_i[m];
            end
            if (addr_i == ADDR_W'(OFF_MCTL + 4 * m)) begin
                rdata_o = ctl_i[m];
            end
        end
    end
endmodule

// File: rtl/pcg_ctrl.sv
// Top of the power and clock gating controller. Decodes register writes,
// instantiates one sequencer per domain and one slot per module, and
// muxes the read data. Assumes one register master issuing at most one
// write per cycle.
module pcg_ctrl
    import pcg_pkg::*;
#(
    parameter int unsigned N_DOM  = 4,
    parameter int unsigned N_MPD  = 2,
    parameter int unsigned T_CYC  = 8,
    parameter int unsigned ADDR_W = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    reg_wr_en,
    input  logic [ADDR_W-1:0]       reg_addr,
    input  logic [31:0]             reg_wdata,
    output logic [31:0]             reg_rdata,
    output logic [N_DOM*N_MPD-1:0]  mod_clk_en,
    output logic [N_DOM*N_MPD-1:0]  mod_rst_n,
    output logic [N_DOM-1:0]        dom_pwr_on
);
    localparam int unsigned N_MOD = N_DOM * N_MPD;

    logic                   cmd_wr;
    logic [N_DOM-1:0]       dom_busy;
    logic [N_DOM-1:0]       dom_take;
    logic [N_DOM-1:0]       dom_done;
    logic [N_DOM-1:0]       dom_req;
    logic [N_DOM-1:0]       dom_on;
    logic [N_MOD-1:0][31:0] mod_ctl;
    logic [N_MOD-1:0][31:0] mod_stat;

    // Command register write strobe.
    assign cmd_wr     = reg_wr_en && (reg_addr == ADDR_W'(OFF_CMD));
    assign dom_pwr_on = dom_on;

    for (genvar d = 0; d < N_DOM; d++) begin : g_dom
        logic req_wr;
        assign req_wr = reg_wr_en && (reg_addr == ADDR_W'(OFF_DCTL + 4 * d));

        pcg_dom_seq #(.T_CYC(T_CYC)) u_seq (
            .clk       (clk),
            .rst_n     (rst_n),
            .start_i   (cmd_wr && reg_wdata[d]),
            .req_wr_i  (req_wr),
            .req_val_i (reg_wdata[0]),
            .busy_o    (dom_busy[d]),
            .take_o    (dom_take[d]),
            .done_o    (dom_done[d]),
            .req_o     (dom_req[d]),
            .on_o      (dom_on[d])
        );
    end

    for (genvar m = 0; m < N_MOD; m++) begin : g_mod
        logic ctl_wr;
        assign ctl_wr = reg_wr_en && (reg_addr == ADDR_W'(OFF_MCTL + 4 * m));

        pcg_mod_slot u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_i      (ctl_wr),
            .w_state_i (reg_wdata[5:0]),
            .w_lrel_i  (reg_wdata[8]),
            .w_force_i (reg_wdata[31]),
            .take_i    (dom_take[m / N_MPD]),
            .done_i    (dom_done[m / N_MPD]),
            .ctl_o     (mod_ctl[m]),
            .stat_o    (mod_stat[m]),
            .clk_en_o  (mod_clk_en[m]),
            .rst_n_o   (mod_rst_n[m])
        );
    end

    pcg_rd_mux #(.N_DOM(N_DOM), .N_MOD(N_MOD), .ADDR_W(ADDR_W)) u_rd (
        .addr_i  (reg_addr),
        .busy_i  (dom_busy),
        .on_i    (dom_on),
        .req_i   (dom_req),
        .ctl_i   (mod_ctl),
        .stat_i  (mod_stat),
        .rdata_o (reg_rdata)
    );
endmodule

// File: rtl/pcg_ctrl_chk.sv
// Checker for pcg_ctrl. It counts the cycles of each busy window and checks
// the sequencing rules. It is bound to every pcg_ctrl instance.
module pcg_ctrl_chk
    import pcg_pkg::*;
#(
    parameter int unsigned N_DOM  = 4,
    parameter int unsigned N_MPD  = 2,
    parameter int unsigned T_CYC  = 8,
    parameter int unsigned ADDR_W = 12
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    wr_en,
    input logic [ADDR_W-1:0]       addr,
    input logic [31:0]             wdata,
    input logic [N_DOM-1:0]        busy,
    input logic [N_DOM-1:0]        done,
    input logic [N_DOM-1:0]        pwr_on,
    input logic [N_DOM*N_MPD-1:0]  clk_en,
    input logic [N_DOM*N_MPD-1:0]  mrst_n
);
    localparam int unsigned N_MOD = N_DOM * N_MPD;

    for (genvar d = 0; d < N_DOM; d++) begin : g_d
        int unsigned bcnt;

        // Number of consecutive busy cycles seen so far.
        always_ff @(posedge clk) begin
            if (!rst_n) bcnt <= 0;
            else if (busy[d]) bcnt <= bcnt + 1;
            else bcnt <= 0;
        end

        p_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && addr == ADDR_W'(OFF_CMD) && wdata[d] && !busy[d]) |=> busy[d]);
        p_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(busy[d]) |-> (bcnt == T_CYC));
        p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (busy[d] && !done[d]) |=> busy[d]);
        p_pwr_r7: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pwr_on[d]) |-> $fell(busy[d]));
    end

    for (genvar m = 0; m < N_MOD; m++) begin : g_m
        p_stage_r2: assert property (@(posedge clk) disable iff (!rst_n)
            !done[m / N_MPD] |=> ($stable(clk_en[m]) && $stable(mrst_n[m])));
    end
endmodule

bind pcg_ctrl pcg_ctrl_chk #(
    .N_DOM(N_DOM), .N_MPD(N_MPD), .T_CYC(T_CYC), .ADDR_W(ADDR_W)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (reg_wr_en),
    .addr   (reg_addr),
    .wdata  (reg_wdata),
    .busy   (dom_busy),
    .done   (dom_done),
    .pwr_on (dom_on),
    .clk_en (mod_clk_en),
    .mrst_n (mod_rst_n)
);

// File: tb/pcg_ctrl_tb_top.sv
`timescale 1ns/1ps
module pcg_ctrl_tb_top;
    localparam int ND = 4;
    localparam int NM = 8;
    localparam int T  = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [NM-1:0] mod_clk_en;
    logic [NM-1:0] mod_rst_n;
    logic [ND-1:0] dom_pwr_on;

    int n_chk = 0;
    int n_fail = 0;

    // Model state
    logic [5:0] m_nxt [NM];
    logic       m_l   [NM];
    logic       m_f   [NM];
    logic [5:0] m_ss  [NM];
    logic       m_sl  [NM];
    logic [5:0] m_cs  [NM];
    logic       m_cl  [NM];
    logic       d_req [ND];
    logic       d_pend[ND];
    logic       d_on  [ND];

    always #2.5 clk = ~clk;

    pcg_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mod_clk_en(mod_clk_en),
        .mod_rst_n(mod_rst_n), .dom_pwr_on(dom_pwr_on)
    );

    function automatic logic [31:0] e_ctl(int m);
        return {m_f[m], 22'b0, m_l[m], 2'b0, m_nxt[m]};
    endfunction
    function automatic logic e_clk(int m);
        return m_cs[m] == 6'd3;
    endfunction
    function automatic logic e_rel(int m);
        return m_cl[m] && (m_cs[m] == 6'd2 || m_cs[m] == 6'd3);
    endfunction
    function automatic logic [31:0] e_stat(int m);
        return {19'b0, e_clk(m), 3'b0, e_rel(m), 2'b0, m_cs[m]};
    endfunction

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", rq, act, exp);
        end
    endtask

    task automatic rd(input int a, output logic [31:0] v);
        reg_addr = 12'(a);
        #0.2;
        v = reg_rdata;
    endtask

    // Drive one write at the current negedge; returns at the next negedge.
    task automatic wr(input int a, input logic [31:0] v);
        reg_addr  = 12'(a);
        reg_wdata = v;
        reg_wr_en = 1'b1;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic wr_mctl(input int m, input logic [31:0] v);
        wr('hA00 + 4 * m, v);
        m_nxt[m] = v[5:0];
        m_l[m]   = v[8];
        m_f[m]   = v[31];
    endtask

    task automatic wr_dctl(input int d, input logic v);
        wr('h300 + 4 * d, {31'b0, v});
        d_req[d] = v;
    endtask

    task automatic model_take(input logic [ND-1:0] mask);
        for (int d = 0; d < ND; d++) begin
            if (mask[d]) begin
                d_pend[d] = d_req[d];
                d_req[d]  = 1'b0;
                for (int k = 0; k < 2; k++) begin
                    m_ss[2*d+k] = m_nxt[2*d+k];
                    m_sl[2*d+k] = m_l[2*d+k];
                end
            end
        end
    endtask

    task automatic model_done(input logic [ND-1:0] mask);
        for (int d = 0; d < ND; d++) begin
            if (mask[d]) begin
                if (d_pend[d]) d_on[d] = 1'b1;
                d_pend[d] = 1'b0;
                for (int k = 0; k < 2; k++) begin
                    m_cs[2*d+k] = m_ss[2*d+k];
                    m_cl[2*d+k] = m_sl[2*d+k];
                end
            end
        end
    endtask

    // Bulk comparison of every readable word and output, then realign.
    task automatic check_all(input string rq);
        logic [31:0] v;
        for (int m = 0; m < NM; m++) begin
            rd('h800 + 4 * m, v); chk({rq, " R4 status"}, v, e_stat(m));
            rd('hA00 + 4 * m, v); chk({rq, " R2 ctl"}, v, e_ctl(m));
            chk({rq, " R5 clk_en"}, 32'(mod_clk_en[m]), 32'(e_clk(m)));
            chk({rq, " R6 rst_n"}, 32'(mod_rst_n[m]), 32'(e_rel(m)));
        end
        for (int d = 0; d < ND; d++) begin
            rd('h200 + 4 * d, v); chk({rq, " R7 dstat"}, v, 32'(d_on[d]));
            rd('h300 + 4 * d, v); chk({rq, " R7 dctl"}, v, 32'(d_req[d]));
            chk({rq, " R7 pwr_on"}, 32'(dom_pwr_on[d]), 32'(d_on[d]));
        end
        @(negedge clk);
    endtask

    // Command, busy window check and completion check.
    task automatic run_cmd(input string rq, input logic [ND-1:0] mask);
        logic [31:0] v;
        wr('h120, 32'(mask));
        model_take(mask);
        rd('h128, v); chk({rq, " R3 busy start"}, v, 32'(mask));
        for (int d = 0; d < ND; d++) begin
            if (mask[d]) begin
                rd('h300 + 4 * d, v); chk({rq, " R7 req cleared"}, v, 32'h0);
            end
        end
        repeat (T - 1) @(negedge clk);
        rd('h128, v); chk({rq, " R3 busy last"}, v, 32'(mask));
        @(negedge clk);
        rd('h128, v); chk({rq, " R3 busy end"}, v, 32'h0);
        model_done(mask);
        check_all(rq);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        logic [31:0] v;
        int unsigned seed;
        seed = 32'd5150;
        v = $urandom(seed);
        for (int m = 0; m < NM; m++) begin
            m_nxt[m] = 0; m_l[m] = 1; m_f[m] = 0;
            m_ss[m] = 0; m_sl[m] = 1; m_cs[m] = 0; m_cl[m] = 1;
        end
        for (int d = 0; d < ND; d++) begin
            d_req[d] = 0; d_pend[d] = 0; d_on[d] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd('hA00, v); chk("R1 ctl reset", v, 32'h0000_0100);
        rd('h128, v); chk("R1 tstat reset", v, 32'h0);
        chk("R1 outputs reset", {mod_clk_en, mod_rst_n, 4'b0, dom_pwr_on}, 32'h0);
        check_all("R1");

        // R10 command register and unmapped offsets read 0
        rd('h120, v); chk("R10 cmd read", v, 32'h0);
        rd('h004, v); chk("R10 unmapped", v, 32'h0);
        rd('hA20, v); chk("R10 past modules", v, 32'h0);
        @(negedge clk);

        // R2 staging: write only changes ctl readback
        wr_mctl(0, 32'hFFFF_FF03);
        check_all("R2 staged");

        // R4/R5/R6/R7 directed: enable module 0, power domain 0
        wr_dctl(0, 1'b1);
        run_cmd("R4 R7 dom0", 4'b0001);

        // R6 clock-off state with reset released, then local reset held
        wr_mctl(1, 32'h0000_0102);
        wr_mctl(0, 32'h0000_0003);
        run_cmd("R6 dom0", 4'b0001);

        // R8 and R2: command while busy is ignored; late write waits
        begin
            logic [5:0] old_s;
            logic       old_l;
            wr_mctl(2, 32'h0000_0103);
            wr('h120, 32'h2);
            model_take(4'b0010);
            old_s = m_ss[2]; old_l = m_sl[2];
            wr_mctl(2, 32'h0000_0101);
            wr('h120, 32'h2);
            repeat (T - 3) @(negedge clk);
            rd('h128, v); chk("R8 still busy", v, 32'h2);
            @(negedge clk);
            rd('h128, v); chk("R8 busy ends on time", v, 32'h0);
            model_done(4'b0010);
            chk("R8 original snapshot", {26'b0, m_cs[2]}, {26'b0, old_s});
            chk("R8 original lrel", 32'(m_cl[2]), 32'(old_l));
            check_all("R8 R2 late write");
        end

        // R9 concurrent domains, then random mixes
        wr_mctl(6, 32'h8000_0103);
        wr_mctl(4, 32'h0000_0002);
        wr_dctl(3, 1'b1);
        run_cmd("R9 multi", 4'b1100 | 4'b0100);

        for (int it = 0; it < 40; it++) begin
            logic [ND-1:0] mask;
            int nw;
            nw = int'($urandom_range(1, 4));
            for (int k = 0; k < nw; k++) begin
                int mi;
                logic [31:0] w;
                mi = int'($urandom_range(0, NM - 1));
                w = $urandom();
                if ($urandom_range(0, 3) != 0) w[5:0] = 6'($urandom_range(0, 3));
                wr_mctl(mi, w);
            end
            if ($urandom_range(0, 2) == 0) wr_dctl(int'($urandom_range(0, ND - 1)), 1'b1);
            mask = 4'($urandom_range(1, 15));
            run_cmd("R9 random", mask);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule